// File: doc/BRIEF.md
# Dual-Channel PWM Output Controller

This block drives a high/low output pin pair from two PWM generators. Each generator counts from zero up to its period value, wraps back to zero and starts again. Its waveform is high while the count is below its duty value. Each generator has its own run bit, end-of-period interrupt flag and clock prescaler select, and these sit in one control byte.

A mode bit decides how the two generators reach the pins. In independent mode, generator 0 drives the high pin and generator 1 drives the low pin. In complementary mode, a select bit picks one generator. Its waveform drives the high pin, and the inverse of that waveform drives the low pin. The selected raw waveform and a dead-time enable also go to a separate dead-time unit. A host programs the block through a byte-wide register port with combinational read data. It receives end-of-period events on one interrupt line.

Top module: `pwm_pair_ctl`

## Requirements
- R1: After reset, the control byte reads 0, both period registers read 0xFF and both duty registers read 0x00. All outputs are low.
- R2: The register addresses are 0 (control), 1 (period of generator 0), 2 (duty of generator 0), 3 (period of generator 1) and 4 (duty of generator 1). A write with `wr_en` high takes effect on the next clock edge. Reads are combinational from the selected register, and addresses 5 to 7 read 0.
- R3: The control byte has these bits:
  - bit 7: generator 0 flag
  - bit 6: generator 0 run
  - bit 5: generator 1 flag
  - bit 4: generator 1 run
  - bit 3: channel select
  - bit 2: complementary mode
  - bit 1: generator 1 prescale
  - bit 0: generator 0 prescale

  A running generator advances its counter on each tick. When the counter equals the period, the tick wraps it to 0 instead. The generator's waveform is high while the counter is below the duty value. While its run bit is clear, its counter is held at 0 and its waveform is low.
- R4: With its prescale bit at 0, a running generator ticks on every clock. With its prescale bit at 1, it ticks on every fourth clock of its run time, starting with the fourth clock.
- R5: A wrap sets that generator's flag, and `irq` is the OR of the two flags.
- R6: A control write with 0 in a flag bit clears that flag, and a 1 in a flag bit leaves the flag unchanged. If a wrap and a clearing write occur on the same edge, the flag ends up set.
- R7: With mode 0, `pwm_hi` follows generator 0 and `pwm_lo` follows generator 1.
- R8: With mode 1, `pwm_hi` follows generator 0 when select is 0 and generator 1 when select is 1. `pwm_lo` is the inverse of `pwm_hi`.
- R9: `dt_en` equals the mode bit, and `dt_src` carries the waveform of the generator chosen by the select bit.
- R10: `pin_en` is high whenever either run bit is set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwm_hi | output | 1 | High-side output |
| pwm_lo | output | 1 | Low-side output |
| dt_en | output | 1 | Dead-time enable |
| dt_src | output | 1 | Selected raw waveform for the dead-time unit |
| pin_en | output | 1 | Pin pair enable |
| irq | output | 1 | Interrupt request |

## Verification
The generators are tried with a duty below the period, a duty above the period (always high), a zero duty (always low) and a zero period (a wrap on every tick). These patterns tell the compare against duty apart from the wrap against period. Running with each prescale setting, on one generator alone and then on both, separates the two tick sources. The same waveforms are routed through independent mode and through complementary mode with each select value. This shows which generator reaches each pin. Flag writes with 0 and with 1, made while the generators run and while they are stopped, separate clearing from keeping.

// File: rtl/pwm_pair_ctl.sv
module pwm_pair_ctl #(
  parameter int W       = 8,
  parameter int PRE_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         pwm_hi,
  output logic         pwm_lo,
  output logic         dt_en,
  output logic         dt_src,
  output logic         pin_en,
  output logic         irq
);
  localparam int DW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(PRE_DIV - 1);

  logic [7:0]   ctrl_q;
  logic [W-1:0] per_q  [2];
  logic [W-1:0] duty_q [2];
  logic [W-1:0] cnt_q  [2];
  logic [DW-1:0] div_q [2];
  logic [1:0]   run, pre, tick, wrap, pwm;
  logic         wr_ctrl, sel_pwm;

  assign run     = {ctrl_q[4], ctrl_q[6]};
  assign pre     = {ctrl_q[1], ctrl_q[0]};
  assign wr_ctrl = wr_en && addr == 3'd0;

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      tick[g] = run[g] && (!pre[g] || div_q[g] == DIV_LAST);
      wrap[g] = tick[g] && cnt_q[g] == per_q[g];
      pwm[g]  = run[g] && cnt_q[g] < duty_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int g = 0; g < 2; g++) begin
        per_q[g]  <= '1;
        duty_q[g] <= '0;
        cnt_q[g]  <= '0;
        div_q[g]  <= '0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (!run[g]) begin
          cnt_q[g] <= '0;
          div_q[g] <= '0;
        end else begin
          div_q[g] <= (div_q[g] == DIV_LAST) ? '0 : div_q[g] + 1'b1;
          if (tick[g]) cnt_q[g] <= wrap[g] ? '0 : cnt_q[g] + 1'b1;
        end
      end
      ctrl_q[7] <= wrap[0] | (ctrl_q[7] & ~(wr_ctrl & ~wdata[7]));
      ctrl_q[5] <= wrap[1] | (ctrl_q[5] & ~(wr_ctrl & ~wdata[5]));
      if (wr_ctrl) begin
        ctrl_q[6]   <= wdata[6];
        ctrl_q[4:0] <= wdata[4:0];
      end
      if (wr_en) begin
        case (addr)
          3'd1: per_q[0]  <= wdata;
          3'd2: duty_q[0] <= wdata;
          3'd3: per_q[1]  <= wdata;
          3'd4: duty_q[1] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = W'(ctrl_q);
      3'd1:    rdata = per_q[0];
      3'd2:    rdata = duty_q[0];
      3'd3:    rdata = per_q[1];
      3'd4:    rdata = duty_q[1];
      default: rdata = '0;
    endcase
  end

  assign sel_pwm = ctrl_q[3] ? pwm[1] : pwm[0];
  assign pwm_hi  = ctrl_q[2] ? sel_pwm : pwm[0];
  assign pwm_lo  = ctrl_q[2] ? ~sel_pwm : pwm[1];
  assign dt_en   = ctrl_q[2];
  assign dt_src  = sel_pwm;
  assign pin_en  = |run;
  assign irq     = ctrl_q[7] | ctrl_q[5];
endmodule

// File: rtl/pwm_pair_ctl_chk.sv
module pwm_pair_ctl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [7:0]   ctrl,
  input logic         pwm_hi,
  input logic         pwm_lo,
  input logic         dt_en,
  input logic         pin_en,
  input logic         irq
);
  a_r8_comp_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    dt_en |-> (pwm_hi != pwm_lo));

  a_r9_dt_en_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dt_en) |-> $past(wr_en && addr == 3'd0 && wdata[2]));

  a_r10_pin_en_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_en) |-> $past(wr_en && addr == 3'd0 && (wdata[6] || wdata[4])));

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en && !dt_en) |-> (!pwm_hi && !pwm_lo));

  a_r5_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pin_en));

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !wdata[7] && !ctrl[6]) |=> !ctrl[7]);
endmodule

bind pwm_pair_ctl pwm_pair_ctl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl(ctrl_q), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .dt_en(dt_en),
  .pin_en(pin_en), .irq(irq)
);

// File: tb/pwm_pair_ctl_tb.sv
module pwm_pair_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic pwm_hi, pwm_lo, dt_en, dt_src, pin_en, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_pair_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .dt_en(dt_en),
    .dt_src(dt_src), .pin_en(pin_en), .irq(irq)
  );

  // behavioural reference state
  int m_ctrl = 0;
  int m_per[2] = '{255, 255};
  int m_duty[2] = '{0, 0};
  int m_cnt[2] = '{0, 0};
  int m_div[2] = '{0, 0};

  function automatic int bitv(int v, int b);
    return (v >> b) & 1;
  endfunction

  function automatic int run_of(int g);
    return bitv(m_ctrl, g == 0 ? 6 : 4);
  endfunction

  function automatic int wave(int g);
    return (run_of(g) != 0 && m_cnt[g] < m_duty[g]) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int setf[2];
    int pre, tk;
    if (!rst_n) begin
      m_ctrl = 0;
      for (int g = 0; g < 2; g++) begin
        m_per[g] = 255; m_duty[g] = 0; m_cnt[g] = 0; m_div[g] = 0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        setf[g] = 0;
        pre = bitv(m_ctrl, g);
        if (run_of(g) != 0) begin
          tk = (pre == 0 || m_div[g] == 3) ? 1 : 0;
          m_div[g] = (m_div[g] + 1) % 4;
          if (tk != 0) begin
            if (m_cnt[g] == m_per[g]) begin m_cnt[g] = 0; setf[g] = 1; end
            else m_cnt[g] = m_cnt[g] + 1;
          end
        end else begin
          m_div[g] = 0; m_cnt[g] = 0;
        end
      end
      begin : flags
        int f0, f1;
        f0 = bitv(m_ctrl, 7); f1 = bitv(m_ctrl, 5);
        if (wr_en && addr == 3'd0) begin
          if (!wdata[7]) f0 = 0;
          if (!wdata[5]) f1 = 0;
          m_ctrl = int'(wdata) & 8'h5F;
        end else begin
          m_ctrl = m_ctrl & 8'h5F;
        end
        if (setf[0] != 0) f0 = 1;
        if (setf[1] != 0) f1 = 1;
        m_ctrl = m_ctrl | (f0 << 7) | (f1 << 5);
      end
      if (wr_en) begin
        case (addr)
          3'd1: m_per[0] = int'(wdata);
          3'd2: m_duty[0] = int'(wdata);
          3'd3: m_per[1] = int'(wdata);
          3'd4: m_duty[1] = int'(wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin : compare
    int sel, hi, lo, rd;
    #1;
    if (!done) begin
      sel = bitv(m_ctrl, 3) != 0 ? wave(1) : wave(0);
      if (bitv(m_ctrl, 2) != 0) begin hi = sel; lo = 1 - sel; end
      else begin hi = wave(0); lo = wave(1); end
      case (addr)
        3'd0: rd = m_ctrl;
        3'd1: rd = m_per[0];
        3'd2: rd = m_duty[0];
        3'd3: rd = m_per[1];
        3'd4: rd = m_duty[1];
        default: rd = 0;
      endcase
      check(rst_n ? "R2/R3/R6 rdata" : "R1 rdata", int'(rdata), rd);
      check(bitv(m_ctrl, 2) != 0 ? "R8 pwm_hi" : "R7 pwm_hi", int'(pwm_hi), hi);
      check(bitv(m_ctrl, 2) != 0 ? "R8 pwm_lo" : "R7 pwm_lo", int'(pwm_lo), lo);
      check("R9 dt_en", int'(dt_en), bitv(m_ctrl, 2));
      check("R9 dt_src", int'(dt_src), sel);
      check("R10 pin_en", int'(pin_en), (run_of(0) | run_of(1)));
      check("R5 irq", int'(irq), bitv(m_ctrl, 7) | bitv(m_ctrl, 5));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2: register setup
    wr(1, 9); wr(2, 3); wr(3, 4); wr(4, 2);
    // R3/R5/R7: both running, independent routing
    wr(0, 8'h50); idle(40);
    // R4: prescale on generator 0, then both
    wr(0, 8'h51); idle(60);
    wr(0, 8'h53); idle(60);
    // R6: write zero to flags while running
    wr(0, 8'h50); idle(5);
    // R6: stop, clear, then write ones to flag bits
    wr(0, 8'h00); wr(0, 8'hA0); idle(5);
    // R8/R9: complementary, select 0 then 1
    wr(0, 8'h54); idle(40);
    wr(0, 8'h5C); idle(40);
    // R3: duty above period, zero duty, zero period
    wr(0, 8'h50); wr(2, 20); idle(30);
    wr(2, 0); idle(20);
    wr(1, 0); wr(2, 1); idle(20);
    // R8: complementary with nothing running
    wr(0, 8'h04); idle(5);
    wr(0, 8'h0C); idle(5);
    // R2: readback across all addresses
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      addr = 3'(a);
    end
    idle(2);
    finish_run();
  end
endmodule